// File: doc/BRIEF.md
# Line Period and Frequency-Range Monitor

This block times each cycle of the mains voltage. It takes the line-direction signal, which is high while the voltage falls and low while it rises. Starting on each high-to-low transition of that signal, it counts pulses of a sample-rate clock enable. When the next transition arrives, it judges the length of the period just finished. A period that is too long, or a line that never transitions at all, raises the frequency-range error at once. A period that is too short raises it only after it has occurred on three measured periods in a row. A period inside the band clears the error and is latched as the current period value.

The same error output also reports that line voltage is missing. An RMS voltage value below a low threshold asserts it. That cause is released only when the value climbs above a higher threshold, which gives hysteresis. A power-enable output feeds the downstream energy integrators. It is low whenever the error is raised, unless an override input is high. With a 4.194304 MHz system clock and a quarter-rate enable, the default limits of 2^15 and 2^13 counts give a valid band of 32 Hz to 128 Hz.

Top module: `line_period_monitor`

## Requirements
- R1: After reset, bfrFlag is 0, powerEn is 1 and periodVal is 0.
- R2: The count is the number of tickEn pulses from one high-to-low transition of lineDir to the next. The edge cycle's own tick counts toward the new period. A count n with SHORT_LIM <= n <= LONG_LIM (SHORT_LIM = 2^SHORT_EXP, LONG_LIM = 2^LONG_EXP) is written to periodVal, which is visible after the clock edge that samples the transition.
- R3: A measured count above LONG_LIM sets bfrFlag on that same edge. periodVal keeps its old value.
- R4: When no transition arrives, the count saturates at LONG_LIM+1. bfrFlag is set on the clock edge after the count reaches that value.
- R5: A count below SHORT_LIM sets bfrFlag only when it is the third such count in a row (STRIKES = 3). The first two leave bfrFlag unchanged.
- R6: An in-band or too-long period resets the run of short periods to zero.
- R7: vRms below LOW_V (64) sets bfrFlag one edge later. This voltage cause is held while vRms stays at or below HIGH_V (128), and it is cleared once vRms exceeds HIGH_V.
- R8: An in-band period clears the frequency cause of bfrFlag.
- R9: powerEn is 0 while bfrFlag is 1 and freqOverride is 0. powerEn is 1 whenever freqOverride is 1.
- R10: The first high-to-low transition after reset only starts counting. It is not judged and does not update periodVal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Sample-rate count enable (system clock / 4) |
| lineDir | input | 1 | Line slope sign: 1 while the voltage falls |
| vRms | input | VRMS_W | RMS voltage register value |
| freqOverride | input | 1 | Forces power computation on despite the error |
| periodVal | output | LONG_EXP+1 | Last in-band period count |
| bfrFlag | output | 1 | Frequency-range or missing-voltage error |
| powerEn | output | 1 | Enable for the downstream power integrators |

## Verification
On every cycle, the assertions check four things:
- The gating of powerEn by the flag and the override.
- That a low vRms raises the flag on the next edge, and that the flag never drops while vRms is below the low threshold.
- That periodVal only changes to an in-band value.
- That periodVal only changes just after a high-to-low transition of lineDir.

The three-strike counting of short periods, its reset by in-band and long periods, the missing-edge timeout with saturation, the hysteresis window between 64 and 128, and the unjudged first edge need ordered period sequences. The bench's scenarios and its behavioural reference model show those.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  // Strobes raised by the datapath for the current cycle
  typedef struct packed {
    logic evalEdge;  // judged falling edge of the line signal
    logic longP;     // running count above the long limit
    logic shortP;    // running count below the short limit
    logic timeout;   // count has reached saturation
  } lpm_meas_t;

  // Strobes returned by the control
  typedef struct packed {
    logic latchPeriod;
  } lpm_ctl_t;

endpackage

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int LONG_LIM  = 32768,
  parameter int SHORT_LIM = 8192
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             lineDir,
  input  lpm_ctl_t         ctl,
  output lpm_meas_t        meas,
  output logic [CNT_W-1:0] periodVal
);

  localparam logic [CNT_W-1:0] SAT_C   = CNT_W'(LONG_LIM + 1);
  localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_LIM);
  localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_LIM);

  logic             linePrev;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic             fallEdge;

  assign fallEdge = linePrev & ~lineDir;

  always_comb begin
    meas.evalEdge = fallEdge & armed;
    meas.longP    = cnt > LONG_C;
    meas.shortP   = cnt < SHORT_C;
    meas.timeout  = cnt == SAT_C;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linePrev  <= 1'b0;
      armed     <= 1'b0;
      cnt       <= '0;
      periodVal <= '0;
    end else begin
      linePrev <= lineDir;
      if (ctl.latchPeriod) periodVal <= cnt;
      if (fallEdge) begin
        armed <= 1'b1;
        cnt   <= tickEn ? CNT_W'(1) : '0;
      end else if (tickEn && cnt != SAT_C) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/lpm_control.sv
module lpm_control
  import lpm_pkg::*;
#(
  parameter int VRMS_W  = 11,
  parameter int LOW_V   = 64,
  parameter int HIGH_V  = 128,
  parameter int STRIKES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  lpm_meas_t         meas,
  input  logic [VRMS_W-1:0] vRms,
  output lpm_ctl_t          ctl,
  output logic              bfrFlag
);

  localparam int SW = $clog2(STRIKES + 1);
  localparam logic [SW-1:0] LAST_C = SW'(STRIKES - 1);

  logic [SW-1:0] strikes;
  logic          freqErr;
  logic          lowV;

  always_comb ctl.latchPeriod = meas.evalEdge & ~meas.longP & ~meas.shortP;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strikes <= '0;
      freqErr <= 1'b0;
    end else if (meas.evalEdge) begin
      if (meas.longP) begin
        freqErr <= 1'b1;
        strikes <= '0;
      end else if (meas.shortP) begin
        if (strikes == LAST_C) freqErr <= 1'b1;
        else strikes <= strikes + SW'(1);
      end else begin
        freqErr <= 1'b0;
        strikes <= '0;
      end
    end else if (meas.timeout) begin
      freqErr <= 1'b1;
      strikes <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) lowV <= 1'b0;
    else if (vRms < VRMS_W'(LOW_V)) lowV <= 1'b1;
    else if (vRms > VRMS_W'(HIGH_V)) lowV <= 1'b0;
  end

  assign bfrFlag = freqErr | lowV;

endmodule

// File: rtl/line_period_monitor.sv
module line_period_monitor
  import lpm_pkg::*;
#(
  parameter int LONG_EXP  = 15,
  parameter int SHORT_EXP = 13,
  parameter int STRIKES   = 3,
  parameter int VRMS_W    = 11,
  parameter int LOW_V     = 64,
  parameter int HIGH_V    = 128
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic                lineDir,
  input  logic [VRMS_W-1:0]   vRms,
  input  logic                freqOverride,
  output logic [LONG_EXP:0]   periodVal,
  output logic                bfrFlag,
  output logic                powerEn
);

  localparam int CNT_W     = LONG_EXP + 1;
  localparam int LONG_LIM  = 2 ** LONG_EXP;
  localparam int SHORT_LIM = 2 ** SHORT_EXP;

  lpm_meas_t meas;
  lpm_ctl_t  ctl;

  lpm_datapath #(
    .CNT_W(CNT_W), .LONG_LIM(LONG_LIM), .SHORT_LIM(SHORT_LIM)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .lineDir(lineDir),
    .ctl(ctl), .meas(meas), .periodVal(periodVal)
  );

  lpm_control #(
    .VRMS_W(VRMS_W), .LOW_V(LOW_V), .HIGH_V(HIGH_V), .STRIKES(STRIKES)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .meas(meas), .vRms(vRms),
    .ctl(ctl), .bfrFlag(bfrFlag)
  );

  assign powerEn = ~bfrFlag | freqOverride;

endmodule

// File: rtl/lpm_checker.sv
module lpm_checker #(
  parameter int LONG_EXP  = 15,
  parameter int SHORT_EXP = 13,
  parameter int VRMS_W    = 11,
  parameter int LOW_V     = 64,
  parameter int HIGH_V    = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic              lineDir,
  input logic [VRMS_W-1:0] vRms,
  input logic              freqOverride,
  input logic [LONG_EXP:0] periodVal,
  input logic              bfrFlag,
  input logic              powerEn
);

  localparam int CNT_W = LONG_EXP + 1;

  a_r9_gate_off: assert property (@(posedge clk) disable iff (!rstN)
    (bfrFlag && !freqOverride) |-> !powerEn);

  a_r9_override_on: assert property (@(posedge clk) disable iff (!rstN)
    freqOverride |-> powerEn);

  a_r7_low_volt_sets: assert property (@(posedge clk) disable iff (!rstN)
    (vRms < VRMS_W'(LOW_V)) |=> bfrFlag);

  a_r7_no_clear_while_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bfrFlag) |-> ($past(vRms) >= VRMS_W'(LOW_V)));

  a_r2_period_in_band: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(periodVal) |-> (periodVal >= CNT_W'(2 ** SHORT_EXP) &&
                             periodVal <= CNT_W'(2 ** LONG_EXP)));

  a_r2_update_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(periodVal) |-> (!$past(lineDir) && $past(lineDir, 2)));

endmodule

bind line_period_monitor lpm_checker #(
  .LONG_EXP(LONG_EXP), .SHORT_EXP(SHORT_EXP), .VRMS_W(VRMS_W),
  .LOW_V(LOW_V), .HIGH_V(HIGH_V)
) u_chk (
  .clk(clk), .rstN(rstN), .lineDir(lineDir), .vRms(vRms),
  .freqOverride(freqOverride), .periodVal(periodVal),
  .bfrFlag(bfrFlag), .powerEn(powerEn)
);

// File: tb/line_period_monitor_bench.sv
`timescale 1ns/1ps
module line_period_monitor_bench;

  localparam int LONG_EXP  = 8;
  localparam int SHORT_EXP = 6;
  localparam int VRMS_W    = 11;
  localparam int LONG      = 2 ** LONG_EXP;
  localparam int SHORT     = 2 ** SHORT_EXP;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b1;
  logic lineDir = 1'b0;
  logic [VRMS_W-1:0] vRms = 11'd200;
  logic freqOverride = 1'b0;
  logic [LONG_EXP:0] periodVal;
  logic bfrFlag, powerEn;

  int checks = 0;
  int errors = 0;
  bit halfTick = 0;
  bit done = 0;

  // reference model state
  int mCnt, mPer, mStr;
  bit mPrev, mArmed, mErr, mLow;

  always #5 clk = ~clk;

  line_period_monitor #(.LONG_EXP(LONG_EXP), .SHORT_EXP(SHORT_EXP), .VRMS_W(VRMS_W))
    u_line_period_monitor (
      .clk(clk), .rstN(rstN), .tickEn(tickEn), .lineDir(lineDir), .vRms(vRms),
      .freqOverride(freqOverride), .periodVal(periodVal),
      .bfrFlag(bfrFlag), .powerEn(powerEn));

  always @(negedge clk) if (halfTick) tickEn <= ~tickEn; else tickEn <= 1'b1;

  // behavioural reference of the requirements
  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mPer = 0; mStr = 0; mPrev = 0; mArmed = 0; mErr = 0; mLow = 0;
    end else begin
      bit fall;
      fall = mPrev && !lineDir;
      if (fall && mArmed) begin
        if (mCnt > LONG) begin mErr = 1; mStr = 0; end
        else if (mCnt < SHORT) begin
          mStr = mStr + 1;
          if (mStr >= 3) begin mErr = 1; mStr = 2; end
        end else begin mErr = 0; mStr = 0; mPer = mCnt; end
      end else if (mCnt == LONG + 1) begin
        mErr = 1; mStr = 0;
      end
      if (vRms < 64) mLow = 1;
      else if (vRms > 128) mLow = 0;
      if (fall) begin mArmed = 1; mCnt = tickEn ? 1 : 0; end
      else if (tickEn && mCnt < LONG + 1) mCnt = mCnt + 1;
      mPrev = lineDir;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      bit eFlag;
      eFlag = mErr | mLow;
      checks++;
      if (bfrFlag !== eFlag || powerEn !== (!eFlag || freqOverride) ||
          periodVal !== (LONG_EXP+1)'(mPer)) begin
        errors++;
        $display("FAIL model R2/R5/R9 at %0t: flag=%0b pwr=%0b per=%0d exp flag=%0b pwr=%0b per=%0d",
                 $time, bfrFlag, powerEn, periodVal, eFlag, !eFlag || freqOverride, mPer);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one falling edge of lineDir, n cycles after the previous one
  task automatic fallIn(input int n);
    for (int i = 0; i < n - 1; i++) begin @(negedge clk); lineDir = 1'b1; end
    @(negedge clk); lineDir = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic stepWait();
    @(negedge clk); @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1 flag", bfrFlag, 0);
    chk("R1 powerEn", powerEn, 1);
    chk("R1 period", periodVal, 0);

    fallIn(100);
    chk("R10 first edge not judged", periodVal, 0);
    fallIn(150);
    chk("R2 period 150", periodVal, 150);
    fallIn(200);
    chk("R2 period 200", periodVal, 200);

    fallIn(300);
    chk("R3 long sets flag", bfrFlag, 1);
    chk("R3 period kept", periodVal, 200);
    chk("R9 power gated", powerEn, 0);
    @(negedge clk); freqOverride = 1'b1;
    @(posedge clk); #1;
    chk("R9 override", powerEn, 1);
    @(negedge clk); freqOverride = 1'b0;
    @(posedge clk); #1;
    fallIn(150);
    chk("R8 in-band clears", bfrFlag, 0);
    chk("R2 period 152", periodVal, 152);

    fallIn(40); chk("R5 strike 1", bfrFlag, 0);
    fallIn(40); chk("R5 strike 2", bfrFlag, 0);
    fallIn(40); chk("R5 strike 3 sets", bfrFlag, 1);
    fallIn(100); chk("R8 clears after short", bfrFlag, 0);

    fallIn(40); fallIn(40); fallIn(120);
    fallIn(40); fallIn(40);
    chk("R6 in-band resets strikes", bfrFlag, 0);
    fallIn(40);
    chk("R6 third after reset sets", bfrFlag, 1);
    fallIn(120);
    fallIn(40); fallIn(40); fallIn(300);
    fallIn(120);
    fallIn(40); fallIn(40);
    chk("R6 long resets strikes", bfrFlag, 0);
    fallIn(120);

    for (int i = 0; i < 299; i++) begin @(negedge clk); lineDir = 1'b1; end
    @(posedge clk); #1;
    chk("R4 missing edge sets", bfrFlag, 1);
    fallIn(2);
    chk("R4 saturated count judged long", bfrFlag, 1);
    fallIn(120);
    chk("R4 recovery", bfrFlag, 0);

    @(negedge clk); vRms = 11'd63;
    @(posedge clk); #1;
    chk("R7 low voltage sets", bfrFlag, 1);
    @(negedge clk); vRms = 11'd100; stepWait();
    chk("R7 hold at 100", bfrFlag, 1);
    @(negedge clk); vRms = 11'd128; stepWait();
    chk("R7 hold at 128", bfrFlag, 1);
    @(negedge clk); vRms = 11'd129;
    @(posedge clk); #1;
    chk("R7 clears above 128", bfrFlag, 0);
    fallIn(100); fallIn(120);
    chk("R2 after voltage test", periodVal, 120);

    halfTick = 1;
    fallIn(300); fallIn(300);
    chk("R2 half-rate ticks", periodVal, 150);
    chk("R8 half-rate in band", bfrFlag, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule